// File: doc/BRIEF.md
# Reference Switch Mode Controller

This block decides the operating mode of a clock synthesizer that can lock to either of two reference inputs. It watches an asynchronous reference select pin, a pin that requests phase-offset compensation, and one validity flag for each reference. It reports the current mode (Normal, Short Holdover, Auto Holdover), which reference is active, whether the compensation unit may run, and a one-cycle strobe that tells the loop to freeze on a stored frequency word.

A level change on the select pin is synchronized and turned into a one-cycle transient pulse. The controller then sits in Short Holdover with compensation forced off for a programmable number of cycles, restarting that wait on every further transient, and then swaps to the other reference and returns to Normal. Independently, if the active reference is reported invalid, the controller enters Auto Holdover and returns to Normal when it is valid again. The loop's frequency word is sampled into a small history ring at a fixed interval, and on entry into holdover the word from a fixed number of samples back is latched, so that the value used predates the disturbance.

Top module: `refsw_mode_ctrl`

## Requirements
- R1: After reset, mode is Normal (code 0), active_ref is 0, comp_en, freeze and mode_chg are 0; a select level of 0 is taken as the reset level.
- R2: A level change on sel_pin moves the controller from Normal to Short Holdover (mode code 1) within 4 clock cycles.
- R3: comp_en is 0 in every cycle in which mode is Short Holdover, whatever the level of comp_en_pin.
- R4: With no further select change, Short Holdover lasts exactly HOLD_CYCLES cycles, after which mode is Normal and active_ref has been inverted exactly once.
- R5: A select change during Short Holdover restarts the HOLD_CYCLES wait without swapping the reference.
- R6: In Normal and Auto Holdover, comp_en follows comp_en_pin with one cycle of delay, including right after returning from Short Holdover.
- R7: In Normal, ref_ok[active_ref]=0 moves the mode to Auto Holdover (code 2); ref_ok[active_ref]=1 there returns it to Normal; the flag of the inactive reference has no effect.
- R8: Each move from Normal into either holdover mode gives one freeze pulse and latches hold_word with the frequency sample taken HO_LAG samples back (one sample every SAMPLE_PERIOD cycles); hold_word stays unchanged while in holdover.
- R9: When fewer than HO_LAG samples have been taken since reset, entry into holdover latches the live freq_word instead.
- R10: mode_chg is high for exactly one cycle after each change of mode and low otherwise.
- R11: A select change while in Auto Holdover moves the controller to Short Holdover, and it then swaps reference as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_pin | input | 1 | Asynchronous reference select level; any change is a transient |
| comp_en_pin | input | 1 | Requests phase-offset compensation |
| ref_ok | input | 2 | Validity flag per reference, bit i for reference i |
| freq_word | input | FREQ_W | Current loop frequency word, sampled into the history ring |
| mode | output | 2 | 0 Normal, 1 Short Holdover, 2 Auto Holdover |
| active_ref | output | 1 | Index of the reference in use |
| comp_en | output | 1 | Enable for the phase-offset compensation unit |
| freeze | output | 1 | One-cycle strobe on entry into holdover |
| hold_word | output | FREQ_W | Frequency word latched for holdover |
| mode_chg | output | 1 | One-cycle strobe on every mode change |

## Verification
The bench builds the block with HOLD_CYCLES=20, SAMPLE_PERIOD=16, HIST_DEPTH=8 and HO_LAG=3 instead of the millisecond-scale defaults. The short wait lets a restarted Short Holdover be told apart from an expired one within a few dozen cycles, and the short sample interval lets the bench hold a frequency value for a known number of sample intervals, so that the latched word shows whether the lag is at least and at most HO_LAG samples. The early-reset holdover case reaches the live-word fallback before the ring has filled.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_SHORT_HO = 2'd1,
    MODE_AUTO_HO  = 2'd2
  } mode_e;
endpackage

// File: rtl/refsw_sync_edge.sv
// Synchronizes the select level and flags every change as a one-cycle pulse.
module refsw_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic pulse
);
  logic [STAGES-1:0] sr;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      last <= 1'b0;
    end else begin
      sr   <= {sr[STAGES-2:0], din};
      last <= sr[STAGES-1];
    end
  end

  assign pulse = sr[STAGES-1] ^ last;
endmodule

// File: rtl/refsw_freq_hist.sv
// Ring of frequency samples; read port written for block RAM inference.
module refsw_freq_hist #(
  parameter int DEPTH  = 8,
  parameter int WIDTH  = 24,
  parameter int PERIOD = 1500000,
  parameter int LAG    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             ok
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(PERIOD);
  localparam int NW = $clog2(LAG + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [CW-1:0]    tick_cnt;
  logic             tick;
  logic [AW-1:0]    wp;
  logic [AW-1:0]    rd_addr;
  logic [NW-1:0]    n_wr;
  logic             ok_q;
  logic [WIDTH-1:0] rd_q;

  assign tick    = (tick_cnt == CW'(PERIOD - 1));
  assign rd_addr = wp - AW'(LAG);

  always_ff @(posedge clk) begin
    if (tick) mem[wp] <= din;
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
      wp       <= '0;
      n_wr     <= '0;
      ok_q     <= 1'b0;
    end else begin
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
      if (tick) begin
        wp <= wp + 1'b1;
        if (n_wr != NW'(LAG)) n_wr <= n_wr + 1'b1;
      end
      ok_q <= (n_wr == NW'(LAG));
    end
  end

  assign dout = rd_q;
  assign ok   = ok_q;
endmodule

// File: rtl/refsw_mode_fsm.sv
module refsw_mode_fsm
  import refsw_pkg::*;
#(
  parameter int HOLD_CYCLES = 1000,
  parameter int WIDTH       = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_pulse,
  input  logic             comp_pin,
  input  logic [1:0]       ref_ok,
  input  logic [WIDTH-1:0] hist_word,
  input  logic             hist_ok,
  input  logic [WIDTH-1:0] live_word,
  output mode_e            state,
  output logic             active_ref,
  output logic             comp_en,
  output logic             freeze,
  output logic [WIDTH-1:0] hold_word,
  output logic             mode_chg
);
  localparam int TW = $clog2(HOLD_CYCLES);

  mode_e         nxt;
  logic [TW-1:0] timer, tmr_n;
  logic          flip;
  logic          enter_ho;

  always_comb begin
    nxt   = state;
    tmr_n = timer;
    flip  = 1'b0;
    case (state)
      MODE_NORMAL: begin
        if (sel_pulse) begin
          nxt   = MODE_SHORT_HO;
          tmr_n = TW'(HOLD_CYCLES - 1);
        end else if (!ref_ok[active_ref]) begin
          nxt = MODE_AUTO_HO;
        end
      end
      MODE_SHORT_HO: begin
        if (sel_pulse) begin
          tmr_n = TW'(HOLD_CYCLES - 1);
        end else if (timer == '0) begin
          nxt  = MODE_NORMAL;
          flip = 1'b1;
        end else begin
          tmr_n = timer - 1'b1;
        end
      end
      MODE_AUTO_HO: begin
        if (sel_pulse) begin
          nxt   = MODE_SHORT_HO;
          tmr_n = TW'(HOLD_CYCLES - 1);
        end else if (ref_ok[active_ref]) begin
          nxt = MODE_NORMAL;
        end
      end
      default: nxt = MODE_NORMAL;
    endcase
  end

  assign enter_ho = (state == MODE_NORMAL) && (nxt != MODE_NORMAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= MODE_NORMAL;
      timer      <= '0;
      active_ref <= 1'b0;
      comp_en    <= 1'b0;
      freeze     <= 1'b0;
      mode_chg   <= 1'b0;
      hold_word  <= '0;
    end else begin
      state    <= nxt;
      timer    <= tmr_n;
      comp_en  <= comp_pin && (nxt != MODE_SHORT_HO);
      freeze   <= enter_ho;
      mode_chg <= (nxt != state);
      if (flip) active_ref <= ~active_ref;
      if (enter_ho) hold_word <= hist_ok ? hist_word : live_word;
    end
  end

  // R3: compensation stays off throughout short holdover
  assert_comp_off_short_R3: assert property (@(posedge clk) disable iff (rst)
    (state == MODE_SHORT_HO) |-> !comp_en);

  // R4: leaving short holdover for normal swaps the reference
  assert_swap_on_return_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == MODE_SHORT_HO && state == MODE_NORMAL) |-> (active_ref != $past(active_ref)));

  // R5: the reference changes on no other transition
  assert_ref_steady_R5: assert property (@(posedge clk) disable iff (rst)
    !($past(state) == MODE_SHORT_HO && state == MODE_NORMAL) |-> $stable(active_ref));

  // R10: every mode change is reported, and only mode changes are
  assert_strobe_on_change_R10: assert property (@(posedge clk) disable iff (rst)
    (state != $past(state)) |-> mode_chg);
  assert_strobe_only_change_R10: assert property (@(posedge clk) disable iff (rst)
    mode_chg |-> (state != $past(state)));

  // R8: freeze only on entry from normal; held word steady in holdover
  assert_freeze_entry_R8: assert property (@(posedge clk) disable iff (rst)
    freeze |-> ($past(state) == MODE_NORMAL && state != MODE_NORMAL));
  assert_hold_steady_R8: assert property (@(posedge clk) disable iff (rst)
    (state != MODE_NORMAL && !freeze) |-> $stable(hold_word));
endmodule

// File: rtl/refsw_mode_ctrl.sv
module refsw_mode_ctrl
  import refsw_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int HOLD_CYCLES   = 1000,
  parameter int FREQ_W        = 24,
  parameter int HIST_DEPTH    = 8,
  parameter int SAMPLE_PERIOD = 1500000,
  parameter int HO_LAG        = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_pin,
  input  logic              comp_en_pin,
  input  logic [1:0]        ref_ok,
  input  logic [FREQ_W-1:0] freq_word,
  output logic [1:0]        mode,
  output logic              active_ref,
  output logic              comp_en,
  output logic              freeze,
  output logic [FREQ_W-1:0] hold_word,
  output logic              mode_chg
);
  logic              sel_pulse;
  logic [FREQ_W-1:0] hist_word;
  logic              hist_ok;
  mode_e             state;

  refsw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(sel_pin), .pulse(sel_pulse)
  );

  refsw_freq_hist #(
    .DEPTH(HIST_DEPTH), .WIDTH(FREQ_W), .PERIOD(SAMPLE_PERIOD), .LAG(HO_LAG)
  ) u_hist (
    .clk(clk), .rst(rst), .din(freq_word), .dout(hist_word), .ok(hist_ok)
  );

  refsw_mode_fsm #(.HOLD_CYCLES(HOLD_CYCLES), .WIDTH(FREQ_W)) u_fsm (
    .clk(clk), .rst(rst), .sel_pulse(sel_pulse), .comp_pin(comp_en_pin),
    .ref_ok(ref_ok), .hist_word(hist_word), .hist_ok(hist_ok),
    .live_word(freq_word), .state(state), .active_ref(active_ref),
    .comp_en(comp_en), .freeze(freeze), .hold_word(hold_word),
    .mode_chg(mode_chg)
  );

  assign mode = state;
endmodule

// File: tb/test_refsw_mode_ctrl.sv
`timescale 1ns/100ps
module test_refsw_mode_ctrl;
  localparam int FW   = 16;
  localparam int HOLD = 20;
  localparam int PER  = 16;
  localparam int LAG  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_pin = 1'b0, comp_en_pin = 1'b0;
  logic [1:0] ref_ok = 2'b11;
  logic [FW-1:0] freq_word = '0;
  logic [1:0] mode;
  logic active_ref, comp_en, freeze, mode_chg;
  logic [FW-1:0] hold_word;

  int errors = 0, checks = 0;
  int n_chg = 0, n_frz = 0, n_s4 = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  refsw_mode_ctrl #(
    .SYNC_STAGES(2), .HOLD_CYCLES(HOLD), .FREQ_W(FW),
    .HIST_DEPTH(8), .SAMPLE_PERIOD(PER), .HO_LAG(LAG)
  ) i_refsw_mode_ctrl (
    .clk(clk), .rst(rst), .sel_pin(sel_pin), .comp_en_pin(comp_en_pin),
    .ref_ok(ref_ok), .freq_word(freq_word), .mode(mode),
    .active_ref(active_ref), .comp_en(comp_en), .freeze(freeze),
    .hold_word(hold_word), .mode_chg(mode_chg)
  );

  always @(negedge clk) begin
    if (mode_chg) n_chg++;
    if (freeze) n_frz++;
    if (mode == 2'd1) n_s4++;
    if (mode == 2'd1 && comp_en) begin
      checks++; errors++;
      $display("FAIL R3 comp_en actual=1 expected=0 in short holdover");
    end
  end

  // sel[15] en[14] ok[13:12] wait[11:4] mode[3:2] ref[1] comp[0]
  localparam logic [15:0] VEC [14] = '{
    {1'b0, 1'b1, 2'b11, 8'd5,  2'd0, 1'b0, 1'b1},  // R6
    {1'b1, 1'b1, 2'b11, 8'd6,  2'd1, 1'b0, 1'b0},  // R2 R3
    {1'b1, 1'b1, 2'b11, 8'd30, 2'd0, 1'b1, 1'b1},  // R4 R6
    {1'b1, 1'b0, 2'b11, 8'd5,  2'd0, 1'b1, 1'b0},  // R6
    {1'b0, 1'b0, 2'b11, 8'd6,  2'd1, 1'b1, 1'b0},  // R2
    {1'b0, 1'b0, 2'b11, 8'd30, 2'd0, 1'b0, 1'b0},  // R4
    {1'b0, 1'b1, 2'b10, 8'd5,  2'd2, 1'b0, 1'b1},  // R7
    {1'b0, 1'b1, 2'b11, 8'd5,  2'd0, 1'b0, 1'b1},  // R7
    {1'b0, 1'b1, 2'b01, 8'd5,  2'd0, 1'b0, 1'b1},  // R7 inactive ignored
    {1'b0, 1'b1, 2'b10, 8'd5,  2'd2, 1'b0, 1'b1},  // R7
    {1'b1, 1'b1, 2'b10, 8'd6,  2'd1, 1'b0, 1'b0},  // R11
    {1'b1, 1'b1, 2'b10, 8'd30, 2'd0, 1'b1, 1'b1},  // R11
    {1'b0, 1'b1, 2'b01, 8'd6,  2'd1, 1'b1, 1'b0},  // R11
    {1'b0, 1'b1, 2'b01, 8'd30, 2'd0, 1'b0, 1'b1}   // R11
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    wait_cyc(5);
    @(negedge clk) rst = 1'b0;
    chk("R1 mode", 32'(mode), 0);
    chk("R1 active_ref", 32'(active_ref), 0);
    chk("R1 comp_en", 32'(comp_en), 0);
    chk("R1 freeze/mode_chg", 32'({freeze, mode_chg}), 0);

    // R9: holdover before the ring holds enough samples uses the live word
    freq_word = 16'h0C0C;
    wait_cyc(3);
    n_frz = 0;
    ref_ok = 2'b10;
    wait_cyc(4);
    chk("R9 mode", 32'(mode), 2);
    chk("R9 hold_word live", 32'(hold_word), 32'h0C0C);
    chk("R8 freeze count", 32'(n_frz), 1);
    ref_ok = 2'b11;
    wait_cyc(4);

    foreach (VEC[i]) begin
      sel_pin     = VEC[i][15];
      comp_en_pin = VEC[i][14];
      ref_ok      = VEC[i][13:12];
      wait_cyc(int'(VEC[i][11:4]));
      chk($sformatf("R2-vector %0d mode R7 R11", i), 32'(mode), 32'(VEC[i][3:2]));
      chk($sformatf("vector %0d active_ref R4", i), 32'(active_ref), 32'(VEC[i][1]));
      chk($sformatf("vector %0d comp_en R6", i), 32'(comp_en), 32'(VEC[i][0]));
    end
    // now: Normal, ref 0, sel 0, en 1, ok 01

    // R4: exact duration of a single short holdover
    ref_ok = 2'b11;
    wait_cyc(3);
    n_s4 = 0;
    sel_pin = 1'b1;
    wait_cyc(40);
    chk("R4 short holdover cycles", 32'(n_s4), HOLD);
    chk("R4 ref swapped", 32'(active_ref), 1);

    // R5 / R10: restart of the wait, one swap, two strobes
    n_chg = 0; n_frz = 0;
    sel_pin = 1'b0;
    wait_cyc(15);
    chk("R5 in short holdover", 32'(mode), 1);
    sel_pin = 1'b1;
    wait_cyc(15);
    chk("R5 restarted wait", 32'(mode), 1);
    chk("R5 no early swap", 32'(active_ref), 1);
    wait_cyc(30);
    chk("R5 back to normal", 32'(mode), 0);
    chk("R5 single swap", 32'(active_ref), 0);
    chk("R10 strobe count", 32'(n_chg), 2);
    chk("R8 one freeze", 32'(n_frz), 1);

    // R8: lag of the latched history word
    freq_word = 16'hAAAA;
    wait_cyc(10 * PER);
    freq_word = 16'hBBBB;
    wait_cyc(PER);
    ref_ok = 2'b10;
    wait_cyc(4);
    chk("R8 hold_word older sample", 32'(hold_word), 32'hAAAA);
    freq_word = 16'h1234;
    wait_cyc(3 * PER);
    chk("R8 hold_word steady", 32'(hold_word), 32'hAAAA);
    ref_ok = 2'b11;
    freq_word = 16'hCCCC;
    wait_cyc((LAG + 1) * PER + 8);
    ref_ok = 2'b10;
    wait_cyc(4);
    chk("R8 hold_word after lag", 32'(hold_word), 32'hCCCC);
    ref_ok = 2'b11;
    wait_cyc(4);
    freq_word = 16'hDDDD;
    wait_cyc(PER + PER / 2);
    ref_ok = 2'b10;
    wait_cyc(4);
    chk("R8 recent samples skipped", 32'(hold_word), 32'hCCCC);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end
endmodule